// File: doc/BRIEF.md
# Multiply hazard interlock controller

This block decides, at the issue stage of an in-order pipeline, how many cycles the instruction now at issue must wait because of a multiply that is still in flight. Each cycle the pipeline presents one instruction descriptor. The descriptor carries a multiply class, up to four source register numbers with an enable bit each, up to two destination register numbers, a flag-setting bit, a conditional bit and a valid bit. The block keeps a small countdown per architectural register, plus one counter for the issue slot and one for a pending flag update. From these it drives a stall count and a stall bit.

The pipeline holds the descriptor steady while the stall bit is high. The instruction issues at the first rising edge where the descriptor is valid and the stall bit is low. No arithmetic, register file or forwarding path is modelled. Only readiness bookkeeping and the stall decision are.

Top module: `mul_hazard_ctrl`

## Requirements
- R1: Class codes on `in_cls` are 0 = not a multiply, 1 = 32-bit word multiply or multiply-accumulate, 2 = 32x32 to 64 long multiply, 3 = halfword, word-by-halfword or dual-16 multiply, 4 = most-significant-word multiply. For classes 1, 2 and 4 the result latency is 3: an ordinary consumer issued one cycle after the multiply stalls 2 cycles. For class 3 the latency is 2, so the same consumer stalls 1 cycle.
- R2: A class 2 multiply makes both `in_dst0` (low word) and `in_dst1` (high word) pending. Any other multiply makes only `in_dst0` pending.
- R3: Sources 2 and 3 (bit 2 and bit 3 of `in_src_en`) are the late, accumulate operands. When the consumer is a multiply, a pending result read through them is usable one cycle earlier than through any other source.
- R4: Sources 0 and 1 are early operands. For a non-multiply consumer, every enabled source waits the full latency.
- R5: Classes 1, 2 and 4 hold the issue slot for 2 cycles. Any valid instruction at issue in the cycle right after such a multiply stalls at least 1 cycle, even with no data dependency.
- R6: After a flag-setting multiply, a conditional (`in_cond`) non-multiply issued in the next cycle stalls 1 cycle, and a conditional multiply stalls 2 cycles.
- R7: After a flag-setting multiply, a flag-setting non-multiply issued in the next cycle stalls 1 cycle. A flag-setting, unconditional multiply gets no flag stall.
- R8: `stall_cnt` is the largest of all applicable dependency counts. While the descriptor is held it falls by exactly one per cycle, and `stall` is high exactly when `stall_cnt` is nonzero.
- R9: A synchronous active-high `rst` clears all pending state, so that no instruction stalls afterwards.
- R10: Register 15 is never recorded as a pending multiply destination.
- R11: A non-multiply (class 0) leaves no pending state behind. A descriptor with `in_valid` low gets `stall_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor at issue is valid |
| in_cls | input | 3 | Multiply class code (see R1) |
| in_src_en | input | 4 | Enable per source: bits 0,1 early, bits 2,3 late |
| in_early0 | input | 4 | Early source register 0 (multiplicand) |
| in_early1 | input | 4 | Early source register 1 (multiplier) |
| in_late0 | input | 4 | Late source register 0 (accumulate / low accumulate) |
| in_late1 | input | 4 | Late source register 1 (high accumulate) |
| in_dst0 | input | 4 | Destination register (low word for long forms) |
| in_dst1 | input | 4 | High-word destination for class 2 |
| in_sets_flags | input | 1 | Instruction updates the condition flags |
| in_cond | input | 1 | Instruction is conditional on the flags |
| stall | output | 1 | Hold the instruction at issue this cycle |
| stall_cnt | output | 2 | Remaining stall cycles for the current descriptor |

## Verification
The countdown and flag properties assume that the pipeline keeps every descriptor field constant while `stall` is high, and changes it only after the instruction issues. The countdown assertion enforces this assumption on itself by ignoring any cycle in which the descriptor bus changed. The stimulus keeps within the assumption: one task drives each descriptor at a falling edge and leaves it untouched until the first falling edge at which `stall` reads low. Only the following falling edge brings a new descriptor or an idle cycle. Each scenario first idles long enough to drain earlier pending state, so that every expected count follows from that scenario alone.

// File: rtl/mhz_pkg.sv
package mhz_pkg;
  typedef enum logic [2:0] {
    MC_NONE = 3'd0,
    MC_WORD = 3'd1,
    MC_LONG = 3'd2,
    MC_HALF = 3'd3,
    MC_MSW  = 3'd4
  } mul_cls_e;

  localparam int NUM_SRC = 4;
  localparam int FIRST_LATE_SRC = 2;
endpackage

// File: rtl/mhz_class_decode.sv
module mhz_class_decode #(
  parameter int CNT_W     = 2,
  parameter int LAT_LONG  = 3,
  parameter int LAT_SHORT = 2
) (
  input  logic [2:0]       cls,
  output logic             is_mul,
  output logic             two_cycle,
  output logic             two_dest,
  output logic [CNT_W-1:0] load_val
);
  import mhz_pkg::*;

  mul_cls_e c;
  assign c = mul_cls_e'(cls);

  always_comb begin
    is_mul    = 1'b1;
    two_cycle = 1'b1;
    two_dest  = 1'b0;
    load_val  = CNT_W'(LAT_LONG - 1);
    unique case (c)
      MC_WORD, MC_MSW: ;
      MC_LONG: two_dest = 1'b1;
      MC_HALF: begin
        two_cycle = 1'b0;
        load_val  = CNT_W'(LAT_SHORT - 1);
      end
      default: begin
        is_mul    = 1'b0;
        two_cycle = 1'b0;
        load_val  = '0;
      end
    endcase
  end
endmodule

// File: rtl/mhz_scoreboard.sv
module mhz_scoreboard #(
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 2,
  parameter int PC_IDX   = 15,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           wr_two,
  input  logic [REG_W-1:0]               wr_idx0,
  input  logic [REG_W-1:0]               wr_idx1,
  input  logic [CNT_W-1:0]               load_val,
  output logic [NUM_REGS-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == PC_IDX) begin : g_pc
      assign cnt[r] = '0;
    end else begin : g_trk
      logic hit;
      assign hit = wr_en && ((wr_idx0 == REG_W'(r)) || (wr_two && (wr_idx1 == REG_W'(r))));
      always_ff @(posedge clk) begin
        if (rst)                 cnt[r] <= '0;
        else if (hit)            cnt[r] <= load_val;
        else if (cnt[r] != '0)   cnt[r] <= cnt[r] - ONE;
      end
    end
  end

  // R9: the cycle after reset leaves every register idle
  a_r9_bank_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt == '0));
endmodule

// File: rtl/mhz_stall_calc.sv
module mhz_stall_calc #(
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 2,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][CNT_W-1:0] cnt,
  input  logic                           occ,
  input  logic [CNT_W-1:0]               flg,
  input  logic                           is_mul,
  input  logic                           sets_flags,
  input  logic                           cond,
  input  logic [3:0]                     src_en,
  input  logic [REG_W-1:0]               early0,
  input  logic [REG_W-1:0]               early1,
  input  logic [REG_W-1:0]               late0,
  input  logic [REG_W-1:0]               late1,
  output logic [CNT_W-1:0]               need
);
  import mhz_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NUM_SRC-1:0][REG_W-1:0] src;
  assign src = {late1, late0, early1, early0};

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  always_comb begin
    logic [CNT_W-1:0] c;
    logic [CNT_W-1:0] fl;
    need = CNT_W'(occ);
    for (int i = 0; i < NUM_SRC; i++) begin
      c = cnt[src[i]];
      if (is_mul && i >= FIRST_LATE_SRC) c = dec_sat(c);
      if (src_en[i] && c > need) need = c;
    end
    fl = '0;
    if (cond)                   fl = is_mul ? flg : dec_sat(flg);
    if (sets_flags && !is_mul && dec_sat(flg) > fl) fl = dec_sat(flg);
    if (fl > need) need = fl;
  end
endmodule

// File: rtl/mul_hazard_ctrl.sv
module mul_hazard_ctrl #(
  parameter int NUM_REGS  = 16,
  parameter int CNT_W     = 2,
  parameter int LAT_LONG  = 3,
  parameter int LAT_SHORT = 2,
  parameter int PC_IDX    = 15,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_cls,
  input  logic [3:0]       in_src_en,
  input  logic [REG_W-1:0] in_early0,
  input  logic [REG_W-1:0] in_early1,
  input  logic [REG_W-1:0] in_late0,
  input  logic [REG_W-1:0] in_late1,
  input  logic [REG_W-1:0] in_dst0,
  input  logic [REG_W-1:0] in_dst1,
  input  logic             in_sets_flags,
  input  logic             in_cond,
  output logic             stall,
  output logic [CNT_W-1:0] stall_cnt
);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] FLAG_HOLD = CNT_W'(2);

  logic             is_mul, two_cycle, two_dest, fire, occ;
  logic [CNT_W-1:0] load_val, flg, need;
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt;

  mhz_class_decode #(.CNT_W(CNT_W), .LAT_LONG(LAT_LONG), .LAT_SHORT(LAT_SHORT)) u_dec (
    .cls(in_cls), .is_mul(is_mul), .two_cycle(two_cycle),
    .two_dest(two_dest), .load_val(load_val)
  );

  assign fire = in_valid && !stall;

  mhz_scoreboard #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .PC_IDX(PC_IDX)) u_sb (
    .clk(clk), .rst(rst), .wr_en(fire && is_mul), .wr_two(two_dest),
    .wr_idx0(in_dst0), .wr_idx1(in_dst1), .load_val(load_val), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= 1'b0;
      flg <= '0;
    end else begin
      occ <= fire && two_cycle;
      if (fire && is_mul && in_sets_flags) flg <= FLAG_HOLD;
      else if (flg != '0)                  flg <= flg - ONE;
    end
  end

  mhz_stall_calc #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W)) u_calc (
    .cnt(cnt), .occ(occ), .flg(flg), .is_mul(is_mul),
    .sets_flags(in_sets_flags), .cond(in_cond), .src_en(in_src_en),
    .early0(in_early0), .early1(in_early1), .late0(in_late0), .late1(in_late1),
    .need(need)
  );

  assign stall_cnt = in_valid ? need : '0;
  assign stall     = (stall_cnt != '0);

  logic [6*REG_W+10:0] desc_bus;
  assign desc_bus = {in_valid, in_cls, in_src_en, in_early0, in_early1, in_late0,
                     in_late1, in_dst0, in_dst1, in_sets_flags, in_cond};

  // R9: no stall in the first cycle after reset
  a_r9_no_stall_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stall_cnt == '0));

  // R5: a two-cycle multiply blocks whatever is at issue next
  a_r5_issue_slot_held: assert property (@(posedge clk) disable iff (rst)
    (fire && two_cycle) |=> (!in_valid || stall));

  // R6: a conditional multiply right behind a flag-setting multiply waits two cycles
  a_r6_cond_mul_two: assert property (@(posedge clk) disable iff (rst)
    (fire && is_mul && in_sets_flags) |=> (!(in_valid && in_cond && is_mul) || stall_cnt == FLAG_HOLD));

  // R8: with the descriptor held, the stall count falls by one each cycle
  a_r8_countdown: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!$stable(desc_bus) || stall_cnt == $past(stall_cnt) - ONE));
endmodule

// File: tb/tb_mul_hazard_ctrl.sv
module tb_mul_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [2:0] in_cls;
  logic [3:0] in_src_en;
  logic [3:0] in_early0, in_early1, in_late0, in_late1, in_dst0, in_dst1;
  logic       in_sets_flags, in_cond;
  logic       stall;
  logic [1:0] stall_cnt;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  mul_hazard_ctrl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_src_en(in_src_en),
    .in_early0(in_early0), .in_early1(in_early1), .in_late0(in_late0), .in_late1(in_late1),
    .in_dst0(in_dst0), .in_dst1(in_dst1), .in_sets_flags(in_sets_flags), .in_cond(in_cond),
    .stall(stall), .stall_cnt(stall_cnt)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Drive at a falling edge, hold while stalled, return after the issuing edge
  task automatic send(string req, int cls, int en, int e0, int e1, int l0, int l1,
                      int d0, int d1, bit fl, bit cd, int exp);
    int first;
    int waited;
    in_valid = 1'b1; in_cls = 3'(cls); in_src_en = 4'(en);
    in_early0 = 4'(e0); in_early1 = 4'(e1); in_late0 = 4'(l0); in_late1 = 4'(l1);
    in_dst0 = 4'(d0); in_dst1 = 4'(d1); in_sets_flags = fl; in_cond = cd;
    #1;
    first = int'(stall_cnt);
    waited = 0;
    check(req, int'(stall), (exp != 0) ? 1 : 0);
    while (stall) begin
      @(negedge clk); #1;
      waited++;
    end
    check(req, first, exp);
    if (exp > 1) check("R8", waited, exp);
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    idle(1);
    send("R9", 0, 4'b0011, 3, 4, 0, 0, 1, 0, 1'b1, 1'b1, 0);
  endtask

  task automatic t_word_latency();
    idle(4);
    send("R1", 1, 0, 0, 0, 0, 0, 3, 0, 1'b0, 1'b0, 0);
    send("R1", 0, 4'b0001, 3, 0, 0, 0, 1, 0, 1'b0, 1'b0, 2);
    idle(4);
    send("R1", 4, 0, 0, 0, 0, 0, 6, 0, 1'b0, 1'b0, 0);
    send("R4", 0, 4'b0010, 0, 6, 0, 0, 1, 0, 1'b0, 1'b0, 2);
  endtask

  task automatic t_half_latency();
    idle(4);
    send("R1", 3, 0, 0, 0, 0, 0, 4, 0, 1'b0, 1'b0, 0);
    send("R1", 0, 4'b0001, 4, 0, 0, 0, 1, 0, 1'b0, 1'b0, 1);
    idle(4);
    send("R3", 3, 0, 0, 0, 0, 0, 4, 0, 1'b0, 1'b0, 0);
    send("R3", 3, 4'b0100, 0, 0, 4, 0, 5, 0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_accumulate();
    idle(4);
    send("R3", 1, 0, 0, 0, 0, 0, 3, 0, 1'b0, 1'b0, 0);
    send("R3", 1, 4'b0100, 0, 0, 3, 0, 5, 0, 1'b0, 1'b0, 1);
    idle(4);
    send("R4", 1, 0, 0, 0, 0, 0, 3, 0, 1'b0, 1'b0, 0);
    send("R4", 1, 4'b0001, 3, 0, 0, 0, 5, 0, 1'b0, 1'b0, 2);
  endtask

  task automatic t_long_dests();
    idle(4);
    send("R2", 2, 0, 0, 0, 0, 0, 5, 6, 1'b0, 1'b0, 0);
    send("R2", 0, 4'b0001, 6, 0, 0, 0, 1, 0, 1'b0, 1'b0, 2);
    idle(4);
    send("R2", 1, 0, 0, 0, 0, 0, 5, 6, 1'b0, 1'b0, 0);
    idle(1);
    send("R2", 0, 4'b0001, 6, 0, 0, 0, 1, 0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_occupancy();
    idle(4);
    send("R5", 1, 0, 0, 0, 0, 0, 8, 0, 1'b0, 1'b0, 0);
    send("R5", 0, 4'b0001, 2, 0, 0, 0, 1, 0, 1'b0, 1'b0, 1);
    idle(4);
    send("R8", 1, 0, 0, 0, 0, 0, 3, 0, 1'b0, 1'b0, 0);
    idle(1);
    send("R8", 0, 4'b0001, 3, 0, 0, 0, 1, 0, 1'b0, 1'b0, 1);
  endtask

  task automatic t_flags();
    idle(4);
    send("R6", 3, 0, 0, 0, 0, 0, 9, 0, 1'b1, 1'b0, 0);
    send("R6", 0, 0, 0, 0, 0, 0, 1, 0, 1'b0, 1'b1, 1);
    idle(4);
    send("R6", 3, 0, 0, 0, 0, 0, 9, 0, 1'b1, 1'b0, 0);
    send("R6", 3, 0, 0, 0, 0, 0, 10, 0, 1'b0, 1'b1, 2);
    idle(4);
    send("R6", 1, 0, 0, 0, 0, 0, 7, 0, 1'b1, 1'b0, 0);
    send("R6", 0, 0, 0, 0, 0, 0, 1, 0, 1'b0, 1'b1, 1);
    idle(4);
    send("R7", 3, 0, 0, 0, 0, 0, 9, 0, 1'b1, 1'b0, 0);
    send("R7", 0, 0, 0, 0, 0, 0, 1, 0, 1'b1, 1'b0, 1);
    idle(4);
    send("R7", 3, 0, 0, 0, 0, 0, 9, 0, 1'b1, 1'b0, 0);
    send("R7", 3, 0, 0, 0, 0, 0, 10, 0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_pc_and_nonmul();
    idle(4);
    send("R10", 3, 0, 0, 0, 0, 0, 15, 0, 1'b0, 1'b0, 0);
    send("R10", 0, 4'b0001, 15, 0, 0, 0, 1, 0, 1'b0, 1'b0, 0);
    idle(4);
    send("R11", 0, 0, 0, 0, 0, 0, 3, 0, 1'b1, 1'b0, 0);
    send("R11", 0, 4'b0001, 3, 0, 0, 0, 1, 0, 1'b0, 1'b1, 0);
    idle(4);
    send("R11", 1, 0, 0, 0, 0, 0, 3, 0, 1'b0, 1'b0, 0);
    in_valid = 1'b0; in_cls = 3'd0; in_src_en = 4'b0001; in_early0 = 4'd3;
    #1;
    check("R11", int'(stall_cnt), 0);
    @(negedge clk);
  endtask

  task automatic t_reset_clears();
    idle(4);
    send("R9", 1, 0, 0, 0, 0, 0, 3, 0, 1'b1, 1'b0, 0);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    send("R9", 0, 4'b0001, 3, 0, 0, 0, 1, 0, 1'b0, 1'b1, 0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_cls = '0; in_src_en = '0;
    in_early0 = '0; in_early1 = '0; in_late0 = '0; in_late1 = '0;
    in_dst0 = '0; in_dst1 = '0; in_sets_flags = 1'b0; in_cond = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_word_latency();
    t_half_latency();
    t_accumulate();
    t_long_dests();
    t_occupancy();
    t_flags();
    t_pc_and_nonmul();
    t_reset_clears();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule